// File: doc/BRIEF.md
# PHY Management Serial Master

This block runs the two-wire PHY management bus from a set of host-programmed fields. The host programs a clock divisor, a preamble-suppress option, a PHY address, a register address and a 16-bit write value. It then raises one of three command bits: write, read or scan. The block generates the management clock and shifts out a serial frame, most significant bit first. The frame is an optional run of 32 ones, the start pair 01, an opcode (01 write, 10 read), the 5-bit PHY address, the 5-bit register address, a two-bit turnaround and 16 data bits.

For a read, the block stops driving the data line from the turnaround onward and samples the PHY's reply on rising clock edges. The captured word is placed in the receive data output at the moment the transaction ends. Scan mode issues reads of the same register back to back for as long as the scan bit stays set. After each scan frame, a link-fail flag is refreshed from the result. A data-invalid flag shows that no scan frame has completed yet. A busy flag covers every transaction.

Top module: `mgmt_master`

## Requirements
- R1: The management clock period is 2*floor(cfg_div/2) system clock cycles, with a minimum of 2 cycles. Bit 0 of cfg_div has no effect: 4 and 5 give the same period.
- R2: A write with the preamble enabled drives 64 bits, all with output enable high. The bits are 32 ones, then 01, opcode 01, phy_addr[4:0], reg_addr[4:0], turnaround 10 and tx_data[15:0], each field most significant bit first.
- R3: stat_busy becomes 1 on the first clock edge after a read or write command bit rises, or after cmd_scan is high, while the block is idle. It returns to 0 at the end of the frame.
- R4: While output enable stays high, mdio_o changes only in cycles where mdc is low, that is, right after a falling management clock edge.
- R5: A read frame drives only the preamble, 01, opcode 10 and the two addresses: 46 bits, or 14 bits without the preamble. Output enable is low from the turnaround on and whenever the block is idle.
- R6: With cfg_nopre set, the 32-bit preamble is left out, and a write drives exactly 32 bits.
- R7: A read samples 16 data bits, most significant bit first, on rising management clock edges. rx_data takes the word on the clock edge where stat_busy falls. A write leaves rx_data unchanged.
- R8: While cmd_scan stays high, the block repeats reads with no idle gap, and stat_busy stays 1 throughout. stat_invalid is set when a scan starts and cleared when the first scan frame completes. rx_data follows each scan result.
- R9: After each scan frame, stat_linkfail is the inverse of bit 2 of the word just read.
- R10: When cmd_scan is cleared, the frame in progress completes and stat_busy then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 8 | Clock divisor, bit 0 ignored |
| cfg_nopre | input | 1 | Leave out the 32-bit preamble |
| cmd_scan | input | 1 | Continuous read of one register while high |
| cmd_read | input | 1 | Single read, started on its rising edge |
| cmd_write | input | 1 | Single write, started on its rising edge |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| tx_data | input | 16 | Value sent by a write |
| rx_data | output | 16 | Last word read |
| stat_busy | output | 1 | Transaction in progress |
| stat_linkfail | output | 1 | Link failure seen by the last scan frame |
| stat_invalid | output | 1 | Scan started but no scan result yet |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line input |

## Verification
Busy is due one clock edge after a command is raised, and the bench checks it at the next falling system clock edge. rx_data, the link-fail flag and the invalid flag change one full management clock period after the last data bit is presented. That edge is the one where busy falls, so the scoreboard compares each transaction result at the first falling system clock edge after busy drops. For scan frames, the bench waits for its PHY model to present the final data bit, then allows 12 cycles before reading the flags. That is more than the period of 4 cycles used in the test and far less than one frame.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
   // Opcode values are the on-wire opcode bits.
   typedef enum logic [1:0] {
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10
   } op_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARM   = 2'd1,
      ST_SHIFT = 2'd2
   } st_t;
endpackage

// File: rtl/mgmt_clkgen.sv
module mgmt_clkgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);
   logic [DIV_W-1:0] half;
   logic [DIV_W-1:0] cnt;
   logic             wrap;

   always_comb begin
      half = div >> 1;
      if (half == '0) half = DIV_W'(1);
      wrap = (cnt >= half - DIV_W'(1));
      rise = wrap && !mdc;
      fall = wrap && mdc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + DIV_W'(1);
      end
   end
endmodule

// File: rtl/mgmt_shifter.sv
module mgmt_shifter
   import mgmt_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 16,
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              fall,
   input  logic              start,
   input  op_t               op,
   input  logic              no_pre,
   input  logic [ADDR_W-1:0] phy,
   input  logic [ADDR_W-1:0] regad,
   input  logic [DATA_W-1:0] wdata,
   input  logic              mdio_i,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              done,
   output logic [DATA_W-1:0] rx
);
   localparam int BODY_LEN = 4 + 2 * ADDR_W + 2 + DATA_W;
   localparam int TA_POS   = 4 + 2 * ADDR_W;
   localparam int FULL_LEN = PRE_LEN + BODY_LEN;
   localparam int CNT_W    = $clog2(FULL_LEN + 1);
   localparam bit HAS_PRE  = (PRE_LEN > 0);

   st_t                st;
   op_t                op_q;
   logic               nopre_q;
   logic [BODY_LEN-1:0] body_q, body_sh;
   logic [CNT_W-1:0]   cnt, last, pos;
   logic               in_pre;

   always_comb begin
      in_pre  = HAS_PRE && !nopre_q && (cnt < CNT_W'(PRE_LEN));
      pos     = (HAS_PRE && !nopre_q) ? cnt - CNT_W'(PRE_LEN) : cnt;
      last    = (HAS_PRE && !nopre_q) ? CNT_W'(FULL_LEN - 1) : CNT_W'(BODY_LEN - 1);
      body_sh = body_q << pos;
      done    = (st == ST_SHIFT) && fall && (cnt == last);
      mdio_o  = 1'b1;
      mdio_oe = 1'b0;
      if (st == ST_SHIFT) begin
         mdio_o  = in_pre ? 1'b1 : body_sh[BODY_LEN-1];
         mdio_oe = in_pre || !(op_q == OP_READ && pos >= CNT_W'(TA_POS));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         op_q    <= OP_READ;
         nopre_q <= 1'b0;
         body_q  <= '0;
         rx      <= '0;
      end else begin
         if (start) begin
            op_q    <= op;
            nopre_q <= no_pre;
            body_q  <= {2'b01, op, phy, regad,
                        (op == OP_WRITE) ? 2'b10 : 2'b11,
                        (op == OP_WRITE) ? wdata : {DATA_W{1'b1}}};
            cnt     <= '0;
            st      <= fall ? ST_SHIFT : ST_ARM;
         end else if (st == ST_ARM && fall) begin
            st <= ST_SHIFT;
         end else if (st == ST_SHIFT && fall) begin
            if (cnt == last) st <= ST_IDLE;
            else             cnt <= cnt + CNT_W'(1);
         end
         if (st == ST_SHIFT && rise && op_q == OP_READ && !in_pre &&
             pos >= CNT_W'(TA_POS + 2))
            rx <= {rx[DATA_W-2:0], mdio_i};
      end
   end
endmodule

// File: rtl/mgmt_master.sv
module mgmt_master
   import mgmt_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 16,
   parameter int PRE_LEN  = 32,
   parameter int LINK_BIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              cfg_nopre,
   input  logic              cmd_scan,
   input  logic              cmd_read,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] phy_addr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] tx_data,
   output logic [DATA_W-1:0] rx_data,
   output logic              stat_busy,
   output logic              stat_linkfail,
   output logic              stat_invalid,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   if (DIV_W < 2) begin : g_bad_div
      $error("mgmt_master: DIV_W must be at least 2");
   end
   if (DATA_W < 2 || LINK_BIT >= DATA_W) begin : g_bad_data
      $error("mgmt_master: LINK_BIT must index a bit of the data word");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("mgmt_master: ADDR_W must be positive");
   end

   logic              rd_q, wr_q, scan_q, cur_rd;
   logic              tick_r, tick_f, done;
   logic              wr_go, rd_go, idle_go, keep_scan, start;
   op_t               op_sel;
   logic [DATA_W-1:0] rx_sh;

   always_comb begin
      wr_go     = cmd_write & ~wr_q;
      rd_go     = cmd_read & ~rd_q;
      idle_go   = !stat_busy && (wr_go || rd_go || cmd_scan);
      keep_scan = done && scan_q && cmd_scan;
      start     = idle_go || keep_scan;
      op_sel    = (idle_go && wr_go) ? OP_WRITE : OP_READ;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q          <= 1'b0;
         wr_q          <= 1'b0;
         stat_busy     <= 1'b0;
         scan_q        <= 1'b0;
         cur_rd        <= 1'b0;
         stat_invalid  <= 1'b0;
         stat_linkfail <= 1'b0;
         rx_data       <= '0;
      end else begin
         rd_q <= cmd_read;
         wr_q <= cmd_write;
         if (idle_go) begin
            stat_busy    <= 1'b1;
            scan_q       <= !wr_go && !rd_go;
            stat_invalid <= !wr_go && !rd_go;
            cur_rd       <= !wr_go;
         end else if (done) begin
            if (cur_rd) rx_data <= rx_sh;
            if (scan_q) begin
               stat_linkfail <= ~rx_sh[LINK_BIT];
               stat_invalid  <= 1'b0;
            end
            if (!keep_scan) begin
               stat_busy <= 1'b0;
               scan_q    <= 1'b0;
            end
         end
      end
   end

   mgmt_clkgen #(.DIV_W(DIV_W)) u_clk (
      .clk  (clk),
      .rst_n(rst_n),
      .div  (cfg_div),
      .mdc  (mdc),
      .rise (tick_r),
      .fall (tick_f)
   );

   mgmt_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_shf (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise   (tick_r),
      .fall   (tick_f),
      .start  (start),
      .op     (op_sel),
      .no_pre (cfg_nopre),
      .phy    (phy_addr),
      .regad  (reg_addr),
      .wdata  (tx_data),
      .mdio_i (mdio_i),
      .mdio_o (mdio_o),
      .mdio_oe(mdio_oe),
      .done   (done),
      .rx     (rx_sh)
   );
endmodule

// File: rtl/mgmt_master_chk.sv
module mgmt_master_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_scan,
   input logic              cmd_read,
   input logic              cmd_write,
   input logic              stat_busy,
   input logic              stat_invalid,
   input logic              mdc,
   input logic              mdio_o,
   input logic              mdio_oe,
   input logic [DATA_W-1:0] rx_data
);
   assert_oe_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> stat_busy);

   assert_drive_on_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> !mdc);

   assert_busy_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_busy) |-> $past(cmd_read || cmd_write || cmd_scan));

   assert_invalid_in_scan_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_invalid |-> stat_busy);

   assert_rx_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_data) |-> ($fell(stat_busy) || stat_busy));
endmodule

bind mgmt_master mgmt_master_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_mgmt_master.sv
`timescale 1ns/1ps
module sim_mgmt_master;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  cfg_div;
   logic        cfg_nopre, cmd_scan, cmd_read, cmd_write;
   logic [4:0]  phy_addr, reg_addr;
   logic [15:0] tx_data, rx_data;
   logic        stat_busy, stat_linkfail, stat_invalid;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   always #2.5 clk = ~clk;

   mgmt_master u0 (.*);

   typedef struct packed {
      logic        is_wr;
      logic        nopre;
      logic [31:0] body;
      logic [15:0] exp_rx;
   } item_t;
   item_t sbq[$];

   int total = 0, bad = 0, cyc = 0, frames = 0, drv_bits = 0, k = 0, r4_bad = 0;
   logic [63:0] seen = '0;
   logic [15:0] phy_word = '0, model_rx = '0;
   logic mdc_p = 0, busy_p = 0, oe_p = 0, o_p = 1, scan_watch = 0, scan_gap = 0;
   bit finished = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog act=%0d exp=<150000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // Monitor: frame decoder, PHY model and scoreboard
   always @(negedge clk) begin
      item_t it;
      if (stat_busy && !busy_p) drv_bits = 0;
      if (mdc && !mdc_p && mdio_oe) begin
         seen = {seen[62:0], mdio_o};
         drv_bits++;
      end
      if (!mdc && mdc_p) begin
         if (mdio_oe || !stat_busy) begin
            k = 0;
            mdio_i = 1'b1;
         end else begin
            k++;
            if (k == 1)       mdio_i = 1'b1;
            else if (k == 2)  mdio_i = 1'b0;
            else if (k <= 18) mdio_i = phy_word[18-k];
            else              mdio_i = 1'b1;
            if (k == 18) frames++;
         end
      end
      if (mdio_oe && oe_p && mdio_o != o_p && mdc) r4_bad++;
      if (scan_watch && !stat_busy) scan_gap = 1;
      if (!stat_busy && busy_p && sbq.size() > 0) begin
         it = sbq.pop_front();
         if (it.is_wr) begin
            chk(it.nopre ? "R6 write frame bits" : "R2 write frame bits", {32'b0, seen[31:0]}, {32'b0, it.body});
            chk(it.nopre ? "R6 write driven count" : "R2 write driven count", drv_bits, it.nopre ? 32 : 64);
            chk("R7 write keeps rx_data", rx_data, it.exp_rx);
         end else begin
            chk("R5 read header bits", seen[13:0], it.body[31:18]);
            chk("R5 read driven count", drv_bits, it.nopre ? 14 : 46);
            chk("R7 read data", rx_data, it.exp_rx);
         end
      end
      mdc_p = mdc; busy_p = stat_busy; oe_p = mdio_oe; o_p = mdio_o;
   end

   task automatic wait_idle();
      while (stat_busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic rise_wait();
      logic pv;
      pv = mdc;
      @(negedge clk);
      while (!(mdc && !pv)) begin
         pv = mdc;
         @(negedge clk);
      end
   endtask

   task automatic meas(input logic [7:0] d, input int exp, input string tag);
      int t0;
      cfg_div = d;
      rise_wait();
      rise_wait();
      t0 = cyc;
      rise_wait();
      chk(tag, cyc - t0, exp);
   endtask

   // Driver: pushes expected results, then issues the command
   task automatic txn(input logic wr, input logic np, input logic [4:0] pa,
                      input logic [4:0] ra, input logic [15:0] d, input logic [15:0] resp);
      item_t it;
      cfg_nopre = np; phy_addr = pa; reg_addr = ra; tx_data = d; phy_word = resp;
      if (!wr) model_rx = resp;
      it.is_wr  = wr;
      it.nopre  = np;
      it.body   = wr ? {4'b0101, pa, ra, 2'b10, d} : {4'b0110, pa, ra, 18'b0};
      it.exp_rx = model_rx;
      sbq.push_back(it);
      @(negedge clk);
      if (wr) cmd_write = 1'b1; else cmd_read = 1'b1;
      @(negedge clk);
      chk("R3 busy one edge after command", stat_busy, 1);
      cmd_write = 1'b0; cmd_read = 1'b0;
      wait_idle();
      chk("R3 busy low after frame", stat_busy, 0);
   endtask

   initial begin
      int f0;
      rst_n = 0; cfg_div = 8'd4; cfg_nopre = 0;
      cmd_scan = 0; cmd_read = 0; cmd_write = 0;
      phy_addr = '0; reg_addr = '0; tx_data = '0;
      repeat (3) @(negedge clk);
      chk("R3 reset busy", stat_busy, 0);
      chk("R5 reset output enable", mdio_oe, 0);
      chk("R8 reset invalid", stat_invalid, 0);
      chk("R9 reset linkfail", stat_linkfail, 0);
      chk("R7 reset rx_data", rx_data, 0);
      rst_n = 1;

      meas(8'd0,  2,  "R1 period div=0");
      meas(8'd5,  4,  "R1 period div=5");
      meas(8'd4,  4,  "R1 period div=4");
      meas(8'd10, 10, "R1 period div=10");
      cfg_div = 8'd4;
      repeat (4) @(negedge clk);

      txn(1, 0, 5'h11, 5'h0A, 16'hC3A5, 16'h0000);
      txn(0, 0, 5'h03, 5'h01, 16'h0000, 16'h8001);
      txn(1, 1, 5'h1F, 5'h1F, 16'h0001, 16'hFFFF);
      txn(0, 1, 5'h00, 5'h15, 16'h0000, 16'h7E5A);
      txn(1, 0, 5'h0C, 5'h02, 16'h5A5A, 16'h1234);

      // Scan
      f0 = frames;
      phy_word = 16'h0000; cfg_nopre = 0; phy_addr = 5'h02; reg_addr = 5'h01;
      @(negedge clk);
      cmd_scan = 1;
      @(negedge clk);
      chk("R8 busy at scan start", stat_busy, 1);
      chk("R8 invalid at scan start", stat_invalid, 1);
      scan_watch = 1;
      while (frames < f0 + 1) @(negedge clk);
      repeat (12) @(negedge clk);
      chk("R8 invalid cleared after first frame", stat_invalid, 0);
      chk("R9 linkfail set when bit2=0", stat_linkfail, 1);
      chk("R8 scan rx_data frame 1", rx_data, 16'h0000);
      phy_word = 16'h0004;
      while (frames < f0 + 2) @(negedge clk);
      repeat (12) @(negedge clk);
      chk("R9 linkfail clear when bit2=1", stat_linkfail, 0);
      chk("R8 scan rx_data frame 2", rx_data, 16'h0004);
      chk("R8 no idle gap during scan", scan_gap, 0);
      scan_watch = 0;
      cmd_scan = 0;
      wait_idle();
      chk("R10 frame in progress completed", frames, f0 + 3);
      chk("R10 busy low after scan", stat_busy, 0);
      chk("R4 drive changes only while mdc low", r4_bad, 0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule